// File: doc/BRIEF.md
# Codec Control Register Access Engine

This block runs the control-register traffic between a host and an audio codec attached over a frame-based AC'97 serial link. The host places one request at a time. A request carries a direction, a 7-bit register index and, for a write, 16 bits of data. While the request is outstanding the engine shows it as busy. When the cycle ends it gives a one-cycle completion strobe, together with the returned read data. A sticky status bit records every read that ended because the codec did not answer.

On the link side the engine works at frame granularity. A strobe marks each frame boundary. In the cycle of that strobe, the incoming tag, command-echo, read-data and GPIO-status slots hold what arrived during the frame that is ending. In the same cycle the engine loads its outgoing tag, command-address and command-data slots for the next frame. Reads are posted: the answer is taken from a later frame, with a bounded wait. The one exception is the codec's GPIO pin-status register, which is answered within the command frame from incoming slot 12. The engine also left-justifies a narrow playback sample into a 20-bit slot.

Top module: `codec_cmd_engine`

## Requirements
- R1: `busy_o` goes to 1 in the cycle after a request is accepted, which needs `req_valid` while idle. It stays at 1 until the completion cycle. A request presented while `busy_o` is 1 is ignored and does not change the command sent or the pending cycle.
- R2: In the command frame, `out_slot1` carries the direction in bit 19 (1 = read, 0 = write) and the index in bits 18:12. Bits 11:0 are zero.
- R3: In the command frame of a write, `out_slot2` bits 19:4 carry the write data and bits 3:0 are zero. For a read, `out_slot2` is all zero.
- R4: The command frame is the first frame that starts after acceptance. In it, `out_slot0` is 16'hE000, meaning bits 15, 14 and 13 are set. In every other frame, `out_slot0`, `out_slot1` and `out_slot2` are zero.
- R5: A write completes at the frame boundary that ends its command frame. At that point `done_o` pulses for one cycle and `busy_o` returns to 0.
- R6: A posted read never completes at the boundary that ends its command frame. A later frame answers it only when incoming slot 0 has bits 14 and 13 set and incoming slot 1 bits 18:12 equal the pending index. `rdata_o` is then incoming slot 2 bits 19:4, zero-extended to 32 bits.
- R7: If none of the four frames after the command frame answers, the read completes at the end of the fourth frame. `rdata_o` is 32'hFFFFFFFF and `rdcs_o` is set.
- R8: A read of index 7'h54 completes at the boundary that ends its command frame. `rdata_o` is incoming slot 12 bits 19:4, zero-extended.
- R9: `rdcs_o` stays set until a cycle with `rdcs_clr` high clears it. If a clear and a timeout fall in the same cycle, the bit stays set.
- R10: `out_slot3` is `play_smp` left-justified in 20 bits, with the unused low bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe from host |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 7 | Codec register index |
| req_wdata | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 32 | Read result, valid with done_o |
| rdcs_o | output | 1 | Sticky read-timeout status |
| rdcs_clr | input | 1 | Clear strobe for rdcs_o |
| frame_tick | input | 1 | Frame boundary strobe |
| out_slot0 | output | 16 | Outgoing tag slot |
| out_slot1 | output | 20 | Outgoing command address slot |
| out_slot2 | output | 20 | Outgoing command data slot |
| in_slot0 | input | 16 | Incoming tag slot of ending frame |
| in_slot1 | input | 20 | Incoming echoed index slot |
| in_slot2 | input | 20 | Incoming read data slot |
| in_slot12 | input | 20 | Incoming GPIO status slot |
| play_smp | input | SMP_W | Playback sample |
| out_slot3 | output | 20 | Justified playback slot |

## Verification
The timeout, which sets the sticky status bit, and a host clear of that bit can land on the same clock edge. The bench provokes this by letting a read run through all four answer frames with no valid response, then raising `rdcs_clr` in the cycle of the final frame strobe. It judges the result by checking that the completion strobe returns the dummy value and that `rdcs_o` is still 1 afterwards. A later clear on its own must then drop the bit.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int IDX_W  = 7;
  localparam int DAT_W  = 16;
  localparam int RES_W  = 32;
  localparam int PAD1_W = SLOT_W - 1 - IDX_W;
  localparam int PAD2_W = SLOT_W - DAT_W;

  typedef enum logic [1:0] {S_IDLE, S_QUEUED, S_SENT, S_WAIT} cce_state_e;

  // command address slot: direction, index, zero stuffing
  function automatic logic [SLOT_W-1:0] f_cmd_addr(input logic rd, input logic [IDX_W-1:0] idx);
    return {rd, idx, {PAD1_W{1'b0}}};
  endfunction

  // command data slot: write data high-aligned, zero for reads
  function automatic logic [SLOT_W-1:0] f_cmd_data(input logic rd, input logic [DAT_W-1:0] d);
    return rd ? '0 : {d, {PAD2_W{1'b0}}};
  endfunction

  // tag slot: frame valid plus slot 1 and slot 2 valid
  function automatic logic [TAG_W-1:0] f_tag(input logic cmd);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = cmd;
    t[TAG_W-2] = cmd;
    t[TAG_W-3] = cmd;
    return t;
  endfunction

  // returned register data from a 20-bit slot, zero-extended
  function automatic logic [RES_W-1:0] f_ret(input logic [SLOT_W-1:0] s);
    return {{(RES_W-DAT_W){1'b0}}, s[SLOT_W-1 -: DAT_W]};
  endfunction

  // echoed index field of incoming slot 1
  function automatic logic [IDX_W-1:0] f_echo_idx(input logic [SLOT_W-1:0] s);
    return s[SLOT_W-2 -: IDX_W];
  endfunction
endpackage

// File: rtl/cce_slot_enc.sv
module cce_slot_enc
  import cce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 send_now,
  input  logic                 cmd_rd,
  input  logic [IDX_W-1:0]     cmd_idx,
  input  logic [DAT_W-1:0]     cmd_dat,
  output logic [TAG_W-1:0]     slot0_o,
  output logic [SLOT_W-1:0]    slot1_o,
  output logic [SLOT_W-1:0]    slot2_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_o <= '0;
      slot1_o <= '0;
      slot2_o <= '0;
    end else if (frame_tick) begin
      slot0_o <= f_tag(send_now);
      slot1_o <= send_now ? f_cmd_addr(cmd_rd, cmd_idx) : '0;
      slot2_o <= send_now ? f_cmd_data(cmd_rd, cmd_dat) : '0;
    end
  end

  assert_tags_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !send_now) |=> (slot0_o == '0 && slot1_o == '0));
  assert_read_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && send_now && cmd_rd) |=> (slot2_o == '0));
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && send_now) |=> (slot1_o[PAD1_W-1:0] == '0 && slot2_o[PAD2_W-1:0] == '0));
endmodule

// File: rtl/cce_resp_check.sv
module cce_resp_check
  import cce_pkg::*;
(
  input  logic [IDX_W-1:0]  pend_idx,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [SLOT_W-1:0] in_echo,
  input  logic [SLOT_W-1:0] in_data,
  input  logic [SLOT_W-1:0] in_gpio,
  output logic              resp_ok,
  output logic [RES_W-1:0]  resp_data,
  output logic [RES_W-1:0]  gpio_data
);
  logic tags_ok;
  logic idx_ok;

  always_comb begin
    tags_ok   = in_tag[TAG_W-2] && in_tag[TAG_W-3];
    idx_ok    = (f_echo_idx(in_echo) == pend_idx);
    resp_ok   = tags_ok && idx_ok;
    resp_data = f_ret(in_data);
    gpio_data = f_ret(in_gpio);
  end
endmodule

// File: rtl/cce_cycle_fsm.sv
module cce_cycle_fsm
  import cce_pkg::*;
#(
  parameter int              TMO_FRAMES = 4,
  parameter logic [IDX_W-1:0] GPIO_IDX  = 7'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [IDX_W-1:0]  req_addr,
  input  logic [DAT_W-1:0]  req_wdata,
  input  logic              frame_tick,
  input  logic              resp_ok,
  input  logic [RES_W-1:0]  resp_data,
  input  logic [RES_W-1:0]  gpio_data,
  input  logic              rdcs_clr,
  output logic              send_now,
  output logic              p_rd,
  output logic [IDX_W-1:0]  p_addr,
  output logic [DAT_W-1:0]  p_data,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  rdata_o,
  output logic              rdcs_o
);
  localparam int CNT_W = $clog2(TMO_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_FRAMES - 1);

  cce_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             accept_ev;
  logic             is_gpio;
  logic             wr_done_ev;
  logic             gpio_done_ev;
  logic             resp_ev;
  logic             tmo_ev;

  always_comb begin
    accept_ev    = (st == S_IDLE) && req_valid;
    send_now     = (st == S_QUEUED);
    is_gpio      = p_rd && (p_addr == GPIO_IDX);
    wr_done_ev   = (st == S_SENT) && frame_tick && !p_rd;
    gpio_done_ev = (st == S_SENT) && frame_tick && is_gpio;
    resp_ev      = (st == S_WAIT) && frame_tick && resp_ok;
    tmo_ev       = (st == S_WAIT) && frame_tick && !resp_ok && (cnt == CNT_LAST);
    busy_o       = (st != S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      p_rd    <= 1'b0;
      p_addr  <= '0;
      p_data  <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (accept_ev) begin
          p_rd   <= req_rd;
          p_addr <= req_addr;
          p_data <= req_wdata;
          st     <= S_QUEUED;
        end
        S_QUEUED: if (frame_tick) st <= S_SENT;
        S_SENT: if (frame_tick) begin
          if (wr_done_ev) begin
            done_o  <= 1'b1;
            rdata_o <= '0;
            st      <= S_IDLE;
          end else if (gpio_done_ev) begin
            done_o  <= 1'b1;
            rdata_o <= gpio_data;
            st      <= S_IDLE;
          end else begin
            cnt <= '0;
            st  <= S_WAIT;
          end
        end
        S_WAIT: if (frame_tick) begin
          if (resp_ev) begin
            done_o  <= 1'b1;
            rdata_o <= resp_data;
            st      <= S_IDLE;
          end else if (tmo_ev) begin
            done_o  <= 1'b1;
            rdata_o <= '1;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // sticky status: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdcs_o <= 1'b0;
    else if (tmo_ev)   rdcs_o <= 1'b1;
    else if (rdcs_clr) rdcs_o <= 1'b0;
  end

  assert_done_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
  assert_ignore_when_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_valid) |=> ($stable(p_addr) && $stable(p_rd) && $stable(p_data)));
  assert_no_same_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SENT) && frame_tick && p_rd && !is_gpio) |=> !done_o);
  assert_dummy_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdcs_o) |-> (done_o && rdata_o == '1));
  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (cnt < CNT_W'(TMO_FRAMES)));
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && rdcs_clr) |=> rdcs_o);
endmodule

// File: rtl/codec_cmd_engine.sv
module codec_cmd_engine
  import cce_pkg::*;
#(
  parameter int               TMO_FRAMES = 4,
  parameter logic [IDX_W-1:0] GPIO_IDX   = 7'h54,
  parameter int               SMP_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_rd,
  input  logic [IDX_W-1:0]     req_addr,
  input  logic [DAT_W-1:0]     req_wdata,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [RES_W-1:0]     rdata_o,
  output logic                 rdcs_o,
  input  logic                 rdcs_clr,
  input  logic                 frame_tick,
  output logic [TAG_W-1:0]     out_slot0,
  output logic [SLOT_W-1:0]    out_slot1,
  output logic [SLOT_W-1:0]    out_slot2,
  input  logic [TAG_W-1:0]     in_slot0,
  input  logic [SLOT_W-1:0]    in_slot1,
  input  logic [SLOT_W-1:0]    in_slot2,
  input  logic [SLOT_W-1:0]    in_slot12,
  input  logic [SMP_W-1:0]     play_smp,
  output logic [SLOT_W-1:0]    out_slot3
);
  logic             send_now;
  logic             p_rd;
  logic [IDX_W-1:0] p_addr;
  logic [DAT_W-1:0] p_data;
  logic             resp_ok;
  logic [RES_W-1:0] resp_data;
  logic [RES_W-1:0] gpio_data;

  cce_cycle_fsm #(.TMO_FRAMES(TMO_FRAMES), .GPIO_IDX(GPIO_IDX)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .frame_tick(frame_tick), .resp_ok(resp_ok), .resp_data(resp_data), .gpio_data(gpio_data),
    .rdcs_clr(rdcs_clr), .send_now(send_now), .p_rd(p_rd), .p_addr(p_addr), .p_data(p_data),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .rdcs_o(rdcs_o)
  );

  cce_slot_enc u_enc (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .send_now(send_now),
    .cmd_rd(p_rd), .cmd_idx(p_addr), .cmd_dat(p_data),
    .slot0_o(out_slot0), .slot1_o(out_slot1), .slot2_o(out_slot2)
  );

  cce_resp_check u_chk (
    .pend_idx(p_addr), .in_tag(in_slot0), .in_echo(in_slot1), .in_data(in_slot2),
    .in_gpio(in_slot12), .resp_ok(resp_ok), .resp_data(resp_data), .gpio_data(gpio_data)
  );

  // playback sample justification
  generate
    if (SMP_W >= SLOT_W) begin : g_full
      assign out_slot3 = play_smp[SMP_W-1 -: SLOT_W];
    end else begin : g_pad
      assign out_slot3 = {play_smp, {(SLOT_W-SMP_W){1'b0}}};
    end
  endgenerate

  assert_cmd_in_tag_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_slot1 != '0) |-> (out_slot0[TAG_W-1 -: 3] == 3'b111));
  assert_write_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(p_rd)) |-> !busy_o);
endmodule

// File: tb/test_codec_cmd_engine.sv
module test_codec_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_rd = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy_o, done_o, rdcs_o;
  logic [31:0] rdata_o;
  logic        rdcs_clr = 1'b0, frame_tick = 1'b0;
  logic [15:0] out_slot0;
  logic [19:0] out_slot1, out_slot2, out_slot3;
  logic [15:0] in_slot0 = '0;
  logic [19:0] in_slot1 = '0, in_slot2 = '0, in_slot12 = '0;
  logic [15:0] play_smp = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic        got_done;
  logic [31:0] got_data;

  always #10 clk = ~clk;

  codec_cmd_engine i_codec_cmd_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .rdcs_o(rdcs_o),
    .rdcs_clr(rdcs_clr), .frame_tick(frame_tick), .out_slot0(out_slot0), .out_slot1(out_slot1),
    .out_slot2(out_slot2), .in_slot0(in_slot0), .in_slot1(in_slot1), .in_slot2(in_slot2),
    .in_slot12(in_slot12), .play_smp(play_smp), .out_slot3(out_slot3)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic rd, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // one frame boundary; captures the completion strobe seen right after it
  task automatic frame_end(input logic clr);
    @(negedge clk);
    frame_tick = 1'b1; rdcs_clr = clr;
    @(negedge clk);
    frame_tick = 1'b0; rdcs_clr = 1'b0;
    got_done = done_o; got_data = rdata_o;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", 32'(busy_o), 0);
    chk("R5 reset done", 32'(done_o), 0);
    chk("R9 reset rdcs", 32'(rdcs_o), 0);
    chk("R4 reset tag", 32'(out_slot0), 0);
  endtask

  task automatic t_write();
    issue(1'b0, 7'h02, 16'hA5C3);
    chk("R1 busy after accept", 32'(busy_o), 1);
    issue(1'b0, 7'h7F, 16'hFFFF); // ignored
    frame_end(1'b0);
    chk("R5 no done in cmd frame", 32'(got_done), 0);
    chk("R4 tag cmd frame", 32'(out_slot0), 32'hE000);
    chk("R2 write addr slot (R1 ignored req)", 32'(out_slot1), 32'h02000);
    chk("R3 write data slot", 32'(out_slot2), 32'hA5C30);
    frame_end(1'b0);
    chk("R5 write done", 32'(got_done), 1);
    chk("R5 busy cleared", 32'(busy_o), 0);
    chk("R4 tag idle frame", 32'(out_slot0), 0);
    chk("R4 addr slot idle", 32'(out_slot1), 0);
  endtask

  task automatic t_read_posted();
    issue(1'b1, 7'h26, 16'h0);
    frame_end(1'b0);
    chk("R2 read addr slot", 32'(out_slot1), 32'hA6000);
    chk("R3 read data slot zero", 32'(out_slot2), 0);
    in_slot0 = 16'h6000; in_slot1 = 20'h26000; in_slot2 = 20'h12340;
    frame_end(1'b0);
    chk("R6 not same frame", 32'(got_done), 0);
    in_slot1 = 20'h28000;
    frame_end(1'b0);
    chk("R6 index mismatch", 32'(got_done), 0);
    in_slot0 = 16'h4000; in_slot1 = 20'h26000;
    frame_end(1'b0);
    chk("R6 missing tag", 32'(got_done), 0);
    in_slot0 = 16'h6000;
    frame_end(1'b0);
    chk("R6 read done", 32'(got_done), 1);
    chk("R6 read data", got_data, 32'h00001234);
    chk("R9 no status on answer", 32'(rdcs_o), 0);
    in_slot0 = '0; in_slot1 = '0; in_slot2 = '0;
  endtask

  task automatic t_timeout(input logic clr_at_end);
    issue(1'b1, 7'h1C, 16'h0);
    frame_end(1'b0);
    frame_end(1'b0);
    chk("R7 no done at cmd frame end", 32'(got_done), 0);
    for (int k = 1; k <= 4; k++) begin
      frame_end((k == 4) ? clr_at_end : 1'b0);
      chk("R7 timeout frame count", 32'(got_done), (k == 4) ? 1 : 0);
    end
    chk("R7 dummy data", got_data, 32'hFFFFFFFF);
    chk("R7 status set (R9 set beats clear)", 32'(rdcs_o), 1);
    @(negedge clk); rdcs_clr = 1'b1;
    @(negedge clk); rdcs_clr = 1'b0;
    chk("R9 cleared", 32'(rdcs_o), 0);
  endtask

  task automatic t_gpio();
    in_slot12 = 20'hBEEF0;
    issue(1'b1, 7'h54, 16'h0);
    frame_end(1'b0);
    chk("R2 gpio addr slot", 32'(out_slot1), 32'hD4000);
    frame_end(1'b0);
    chk("R8 gpio done same frame", 32'(got_done), 1);
    chk("R8 gpio data", got_data, 32'h0000BEEF);
    in_slot12 = '0;
  endtask

  task automatic t_play();
    play_smp = 16'hABCD; #1;
    chk("R10 justify", 32'(out_slot3), 32'hABCD0);
    play_smp = 16'h0001; #1;
    chk("R10 low bits zero", 32'(out_slot3), 32'h00010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_posted();
    t_timeout(1'b0);
    t_timeout(1'b1);
    t_gpio();
    t_play();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule